// File: doc/BRIEF.md
# Two-Stage Signed Multiply-Accumulate Unit

This block multiplies two signed two's-complement operands and adds the product to a running sum. It has two register stages. The first stage builds the partial products and compresses them to two rows that are still in carry-save form. Each row carries a fixed, known bias, so the true sum of the two rows is never negative and never wraps. The second stage removes that bias and sign-extends the product in one step, by adding a single constant row. It then merges the pair with the accumulator through carry-save adders and resolves the result with a Kogge-Stone prefix adder. No carry-propagate adder sits between the multiplier and the accumulator.

The accumulator is wider than the product by a set of guard bits, so intermediate sums can leave the output range and come back without losing information. The visible result is clamped to the signed product range. A sticky flag records that clamping has taken place at some point. A pair presented with the clear control starts a new sum: its product replaces the accumulated value.

A pair is accepted on each rising edge where the valid strobe is high. Its effect appears on the outputs after the second rising edge. Cycles without valid leave the accumulator and the flag untouched, so a host can stream one pair per cycle or present pairs sparsely.

Top module: `csa_mac_unit`

## Requirements
- R1: While the active-low reset is low, and after it is released, `acc_out` reads 0 and `ovf_flag` reads 0 until a pair is accumulated.
- R2: A pair sampled with `in_valid` and `acc_clear` both high at edge k makes `acc_out` equal to the signed product `op_a*op_b` after edge k+1. The outputs still show the previous result after edge k.
- R3: A pair sampled with `in_valid` high and `acc_clear` low adds its signed product to the internal accumulator. `acc_out` shows the new sum after the following edge.
- R4: Edges where `in_valid` is low change neither the accumulator nor `ovf_flag`. The operand and clear inputs are ignored on those edges.
- R5: Operands are 8-bit two's complement values, with bit 7 as the sign. All corner products are exact, including -128*-128 = 16384, -128*127 = -16256 and -1*-1 = 1.
- R6: When the internal sum exceeds 32767, `acc_out` reads 16'h7FFF and `ovf_flag` becomes 1.
- R7: When the internal sum is below -32768, `acc_out` reads 16'h8000 and `ovf_flag` becomes 1.
- R8: The internal accumulator is 24 bits wide (8 guard bits). A sum that leaves the 16-bit range and later returns into it is shown exactly.
- R9: `ovf_flag` is sticky. It stays 1 while later sums are in range, and it falls only when a clearing pair produces an in-range product.
- R10: Pairs presented on consecutive cycles are all accumulated. `acc_out` shows one new partial sum per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| acc_clear | input | 1 | With `in_valid`: start a new sum with this product |
| op_a | input | 8 | Multiplicand, two's complement |
| op_b | input | 8 | Multiplier, two's complement |
| acc_out | output | 16 | Accumulated value, clamped to the signed 16-bit range |
| ovf_flag | output | 1 | Sticky flag: clamping has occurred since the last clear |

## Verification
The properties look back two edges from each output change to the strobe and clear that caused it. They therefore assume that `in_valid` and `acc_clear` are known at every edge, and that reset stays low for at least two edges with the strobe low. The bench drives all inputs on falling edges. It holds `in_valid` at 0 through every reset, which lasts four cycles, so the two-edge look-back never reaches a value from before or across a reset. The clamp-on-set property assumes that the flag is only ever set by an out-of-range sum. The stimulus reaches both the positive and the negative bound, as well as a return from far outside the range, to exercise that path.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int unsigned DEF_OP_W    = 8;
    localparam int unsigned DEF_GUARD_W = 8;

    // Each of the n partial-product rows is offset by 2^(n-1) so it is
    // non-negative; the offsets sum to (2^n - 1) * 2^(n-1).
    function automatic int unsigned bias_of(input int unsigned n);
        return ((32'd1 << n) - 32'd1) << (n - 1);
    endfunction

endpackage

// File: rtl/pp_tree.sv
// Stage-one datapath: biased partial products and a 3:2 reduction tree.
module pp_tree #(
    parameter int unsigned OP_W = 8,
    localparam int unsigned PW  = 2 * OP_W,
    localparam int unsigned NR  = OP_W + 1
) (
    input  logic [OP_W-1:0] a,
    input  logic [OP_W-1:0] b,
    output logic [PW-1:0]   row_s,
    output logic [PW-1:0]   row_c
);

    localparam logic [OP_W-1:0] TOPBIT = {1'b1, {(OP_W-1){1'b0}}};

    logic [PW-1:0] rows [NR];

    // Rows below the sign row: b[i]*a + 2^(OP_W-1), made unsigned by
    // flipping the sign bit of the operand.
    for (genvar gi = 0; gi < OP_W - 1; gi++) begin : g_row
        logic [OP_W-1:0] body;
        assign body     = b[gi] ? (a ^ TOPBIT) : TOPBIT;
        assign rows[gi] = {{OP_W{1'b0}}, body} << gi;
    end

    // Sign row subtracts a: ~a + 1, with the +1 placed in an extra row.
    logic [OP_W-1:0] sign_body;
    assign sign_body      = b[OP_W-1] ? {a[OP_W-1], ~a[OP_W-2:0]} : TOPBIT;
    assign rows[OP_W-1]   = {{OP_W{1'b0}}, sign_body} << (OP_W - 1);
    assign rows[OP_W]     = {{(PW-1){1'b0}}, b[OP_W-1]} << (OP_W - 1);

    // Wallace-style reduction: each level groups rows by three.
    always_comb begin
        logic [PW-1:0] wk [NR];
        logic [PW-1:0] nx [NR];
        logic [PW-1:0] x, y, z;
        int cnt, nc, grp;
        wk  = rows;
        cnt = NR;
        for (int lv = 0; lv < NR; lv++) begin
            if (cnt > 2) begin
                for (int r = 0; r < NR; r++) nx[r] = '0;
                grp = cnt / 3;
                nc  = 0;
                for (int gi = 0; gi < NR / 3; gi++) begin
                    if (gi < grp) begin
                        x = wk[3*gi];
                        y = wk[3*gi+1];
                        z = wk[3*gi+2];
                        nx[nc]   = x ^ y ^ z;
                        nx[nc+1] = ((x & y) | (x & z) | (y & z)) << 1;
                        nc = nc + 2;
                    end
                end
                for (int r = 0; r < NR; r++) begin
                    if (r >= 3 * grp && r < cnt) begin
                        nx[nc] = wk[r];
                        nc = nc + 1;
                    end
                end
                wk  = nx;
                cnt = nc;
            end
        end
        row_s = wk[0];
        row_c = wk[1];
    end

endmodule

// File: rtl/ks_prefix_adder.sv
// Kogge-Stone carry-propagate adder, carry-in zero, result modulo 2^W.
module ks_prefix_adder #(
    parameter int unsigned W = 24,
    localparam int unsigned LV = $clog2(W)
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);

    logic [W-1:0] half;
    assign half = x ^ y;

    always_comb begin
        logic [W-1:0] g, p;
        int d;
        g = x & y;
        p = half;
        for (int lv = 0; lv < LV; lv++) begin
            d = 1 << lv;
            // Descending index keeps each level reading the previous one.
            for (int i = W - 1; i >= 0; i--) begin
                if (i >= d) begin
                    g[i] = g[i] | (p[i] & g[i-d]);
                    p[i] = p[i] & p[i-d];
                end
            end
        end
        sum = half ^ {g[W-2:0], 1'b0};
    end

endmodule

// File: rtl/acc_merge.sv
// Stage-two datapath: sign fix-up, carry-save merge, prefix resolution.
module acc_merge
    import mac_pkg::*;
#(
    parameter int unsigned OP_W  = 8,
    parameter int unsigned AW    = 24,
    localparam int unsigned PW   = 2 * OP_W
) (
    input  logic [AW-1:0] acc_q,
    input  logic          restart,
    input  logic [PW-1:0] row_s,
    input  logic [PW-1:0] row_c,
    output logic [AW-1:0] acc_nx
);

    // Adding -bias modulo 2^AW both removes the row offsets and
    // sign-extends the product: one constant row does both.
    localparam logic [AW-1:0] FIX_ROW = ~AW'(bias_of(OP_W)) + 1'b1;

    logic [AW-1:0] base, es, ec;
    logic [AW-1:0] s1, c1, s2, c2;

    assign base = restart ? '0 : acc_q;
    assign es   = {{(AW-PW){1'b0}}, row_s};
    assign ec   = {{(AW-PW){1'b0}}, row_c};

    assign s1 = base ^ es ^ ec;
    assign c1 = ((base & es) | (base & ec) | (es & ec)) << 1;
    assign s2 = s1 ^ c1 ^ FIX_ROW;
    assign c2 = ((s1 & c1) | (s1 & FIX_ROW) | (c1 & FIX_ROW)) << 1;

    ks_prefix_adder #(.W(AW)) u_cpa (
        .x   (s2),
        .y   (c2),
        .sum (acc_nx)
    );

endmodule

// File: rtl/sat_clamp.sv
// Clamp a wide signed value to the signed PW-bit range.
module sat_clamp #(
    parameter int unsigned AW = 24,
    parameter int unsigned PW = 16
) (
    input  logic [AW-1:0] v,
    output logic [PW-1:0] y,
    output logic          oor
);

    logic [AW-PW:0] upper;
    assign upper = v[AW-1:PW-1];
    assign oor   = ~((&upper) | ~(|upper));

    always_comb begin
        if (!oor)          y = v[PW-1:0];
        else if (v[AW-1])  y = {1'b1, {(PW-1){1'b0}}};
        else               y = {1'b0, {(PW-1){1'b1}}};
    end

endmodule

// File: rtl/csa_mac_unit.sv
module csa_mac_unit
    import mac_pkg::*;
#(
    parameter int unsigned OP_W     = DEF_OP_W,
    parameter int unsigned GUARD_W  = DEF_GUARD_W,
    localparam int unsigned PROD_W  = 2 * OP_W,
    localparam int unsigned ACC_W   = PROD_W + GUARD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              acc_clear,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [PROD_W-1:0] acc_out,
    output logic              ovf_flag
);

    typedef struct packed {
        logic              s1_vld;
        logic              s1_clr;
        logic [PROD_W-1:0] s1_rs;
        logic [PROD_W-1:0] s1_rc;
        logic [ACC_W-1:0]  acc;
        logic [PROD_W-1:0] shown;
        logic              ovf;
    } mac_state_t;

    mac_state_t st_d, st_q;

    logic [PROD_W-1:0] tree_s, tree_c;
    logic [ACC_W-1:0]  acc_nx;
    logic [PROD_W-1:0] shown_nx;
    logic              oor_nx;

    pp_tree #(.OP_W(OP_W)) u_tree (
        .a     (op_a),
        .b     (op_b),
        .row_s (tree_s),
        .row_c (tree_c)
    );

    acc_merge #(.OP_W(OP_W), .AW(ACC_W)) u_merge (
        .acc_q   (st_q.acc),
        .restart (st_q.s1_clr),
        .row_s   (st_q.s1_rs),
        .row_c   (st_q.s1_rc),
        .acc_nx  (acc_nx)
    );

    sat_clamp #(.AW(ACC_W), .PW(PROD_W)) u_sat (
        .v   (acc_nx),
        .y   (shown_nx),
        .oor (oor_nx)
    );

    always_comb begin
        st_d        = st_q;
        st_d.s1_vld = in_valid;
        if (in_valid) begin
            st_d.s1_clr = acc_clear;
            st_d.s1_rs  = tree_s;
            st_d.s1_rc  = tree_c;
        end
        if (st_q.s1_vld) begin
            st_d.acc   = acc_nx;
            st_d.shown = shown_nx;
            st_d.ovf   = (st_q.ovf & ~st_q.s1_clr) | oor_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_out  = st_q.shown;
    assign ovf_flag = st_q.ovf;

endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
    parameter int unsigned PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          acc_clear,
    input logic [PW-1:0] acc_out,
    input logic          ovf_flag
);

    localparam logic [PW-1:0] POS_MAX = {1'b0, {(PW-1){1'b1}}};
    localparam logic [PW-1:0] NEG_MIN = {1'b1, {(PW-1){1'b0}}};

    // R4: no strobe two edges back -> result unchanged
    a_r4_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid, 2) |-> $stable(acc_out));

    // R4: no strobe two edges back -> flag unchanged
    a_r4_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid, 2) |-> $stable(ovf_flag));

    // R9: the sticky flag only drops after a clearing pair was accepted
    a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> ($past(in_valid, 2) && $past(acc_clear, 2)));

    // R6 / R7: a newly raised flag comes with a clamped output
    a_r6_clamp_on_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (acc_out == POS_MAX || acc_out == NEG_MIN));

endmodule

bind csa_mac_unit mac_checker #(.PW(PROD_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .acc_clear (acc_clear),
    .acc_out   (acc_out),
    .ovf_flag  (ovf_flag)
);

// File: tb/csa_mac_unit_tb_top.sv
`timescale 1ns/1ps
module csa_mac_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        acc_clear = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic [15:0] acc_out;
    logic        ovf_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    csa_mac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_clear(acc_clear),
        .op_a(op_a), .op_b(op_b), .acc_out(acc_out), .ovf_flag(ovf_flag)
    );

    // {a, b, clear, expected acc_out, expected flag}
    localparam int NV = 20;
    localparam logic [33:0] VEC [NV] = '{
        {8'h03, 8'h05, 1'b1, 16'h000F, 1'b0},   // R2
        {8'hFC, 8'h07, 1'b0, 16'hFFF3, 1'b0},   // R3
        {8'h80, 8'h80, 1'b1, 16'h4000, 1'b0},   // R5
        {8'h80, 8'h7F, 1'b0, 16'h0080, 1'b0},   // R5
        {8'h7F, 8'h80, 1'b1, 16'hC080, 1'b0},   // R5
        {8'hFF, 8'hFF, 1'b0, 16'hC081, 1'b0},   // R5
        {8'h00, 8'hB3, 1'b1, 16'h0000, 1'b0},   // R2
        {8'h7F, 8'h7F, 1'b0, 16'h3F01, 1'b0},   // R3
        {8'h7F, 8'h7F, 1'b0, 16'h7E02, 1'b0},   // R3
        {8'h01, 8'h01, 1'b0, 16'h7E03, 1'b0},   // R3
        {8'h7F, 8'h7F, 1'b0, 16'h7FFF, 1'b1},   // R6
        {8'h80, 8'h7F, 1'b0, 16'h7D84, 1'b1},   // R8 R9
        {8'h02, 8'h03, 1'b1, 16'h0006, 1'b0},   // R9
        {8'h80, 8'h80, 1'b1, 16'h4000, 1'b0},   // R5
        {8'h80, 8'h80, 1'b0, 16'h7FFF, 1'b1},   // R6
        {8'h80, 8'h7F, 1'b1, 16'hC080, 1'b0},   // R9
        {8'h80, 8'h7F, 1'b0, 16'h8100, 1'b0},   // R3
        {8'hFF, 8'h01, 1'b0, 16'h80FF, 1'b0},   // R3
        {8'h80, 8'h02, 1'b0, 16'h8000, 1'b1},   // R7
        {8'h01, 8'h01, 1'b0, 16'h8000, 1'b1}    // R8
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] a, input logic [7:0] b, input logic clr);
        @(negedge clk);
        op_a = a; op_b = b; acc_clear = clr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; acc_clear = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset acc", acc_out, 16'h0000);
        check("R1 reset flag", {15'd0, ovf_flag}, 16'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after release acc", acc_out, 16'h0000);

        for (int k = 0; k < NV; k++) begin
            push(VEC[k][33:26], VEC[k][25:18], VEC[k][17]);
            check($sformatf("R2/R3/R5-R9 vec%0d acc", k), acc_out, VEC[k][16:1]);
            check($sformatf("R6/R7/R9 vec%0d flag", k), {15'd0, ovf_flag}, {15'd0, VEC[k][0]});
        end

        // R2 latency: nothing after the first edge, product after the second
        @(negedge clk);
        op_a = 8'd10; op_b = 8'd10; acc_clear = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; acc_clear = 1'b0;
        check("R2 not yet after one edge", acc_out, 16'h8000);
        @(negedge clk);
        check("R2 product after two edges", acc_out, 16'd100);
        check("R2 flag cleared", {15'd0, ovf_flag}, 16'd0);

        // R4: strobe low, other inputs busy
        op_a = 8'h7F; op_b = 8'h7F; acc_clear = 1'b1;
        repeat (5) @(negedge clk);
        check("R4 acc ignored inputs", acc_out, 16'd100);
        check("R4 flag ignored inputs", {15'd0, ovf_flag}, 16'd0);
        acc_clear = 1'b0;

        // R10: back-to-back pairs
        @(negedge clk);
        op_a = 8'd2; op_b = 8'd2; acc_clear = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        op_a = 8'd3; op_b = 8'd3; acc_clear = 1'b0;
        @(negedge clk);
        check("R10 first partial sum", acc_out, 16'd4);
        op_a = 8'd4; op_b = 8'd4;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 second partial sum", acc_out, 16'd13);
        @(negedge clk);
        check("R10 third partial sum", acc_out, 16'd29);

        // R8: go far above range, return exactly
        push(8'h80, 8'h80, 1'b1);
        for (int k = 0; k < 9; k++) push(8'h80, 8'h80, 1'b0);
        check("R8 far above range clamps", acc_out, 16'h7FFF);
        for (int k = 0; k < 10; k++) push(8'h80, 8'h7F, 1'b0);
        check("R8 exact after return", acc_out, 16'd1280);
        check("R9 flag still set", {15'd0, ovf_flag}, 16'd1);

        // R1: reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 mid-run reset acc", acc_out, 16'h0000);
        check("R1 mid-run reset flag", {15'd0, ovf_flag}, 16'd0);
        rst_n = 1'b1;
        push(8'hF9, 8'h06, 1'b0);
        check("R3 accumulate after reset", acc_out, 16'hFFD6);

        finish_run();
    end

endmodule